// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block holds the interrupt status of a CAN controller. It watches the receive and transmit error counters, the bus-off state and three per-mailbox vectors: remote frames pending, data frames pending and the mailbox interrupt mask. From these it keeps four status flags and drives one combined interrupt request.

The two error-warning flags latch when their counter first crosses the warning threshold. Software clears them by writing 1. The two summary flags follow the mailbox vectors directly and cannot be written. A second register holds one interrupt-enable mask bit per flag and sets which flags reach the interrupt line. Both registers sit on a small word-wide port. Writes are synchronous and reads are combinational. Address 0 selects the status register and address 1 selects the enable mask.

Top module: `can_irq_flags`

## Requirements
- R1: The receive warning flag (status bit 4) becomes 1 on the clock edge that follows a cycle in which the receive error counter first reaches 96 or more while bus-off is low. Only the rising edge of that condition sets the flag.
- R2: While bus-off is high, the receive warning flag is not set, whatever the receive counter holds. The transmit warning flag does not depend on bus-off.
- R3: The transmit warning flag (status bit 3) becomes 1 on the clock edge after the transmit error counter first reaches 96 or more.
- R4: Writing 1 to bit 4 or bit 3 at address 0 clears that flag. The flag stays clear while its counter remains at 96 or above. Writing 0 to a bit leaves that flag unchanged.
- R5: If a set edge and a write-1 clear of the same warning flag fall in the same cycle, the flag ends up 1.
- R6: The remote flag (status bit 2) is 1 exactly when some mailbox has its remote-pending bit at 1 and its mask bit at 0. It is therefore 0 when no remote frame is pending, or when every pending mailbox is masked.
- R7: The data flag (status bit 1) is 1 exactly when some mailbox has its data-pending bit at 1 and its mask bit at 0.
- R8: Writes to status bits 2 and 1 have no effect. Status bits 0 and 5 and above always read 0.
- R9: The enable mask at address 1 keeps its bits at positions 4 to 1, which line up with the status flags. It can be read and written. The interrupt request is 1 exactly when some flag is 1 and its enable mask bit is 0.
- R10: Reset clears both warning flags and sets all four enable mask bits to 1, so address 1 reads 0x1E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_err_cnt_i | input | 8 | Receive error counter |
| tx_err_cnt_i | input | 8 | Transmit error counter |
| bus_off_i | input | 1 | Controller is in bus-off |
| rmt_pend_i | input | N_MBX | Remote frame pending bit for each mailbox |
| dat_pend_i | input | N_MBX | Data frame pending bit for each mailbox |
| mbx_mask_i | input | N_MBX | Interrupt mask bit for each mailbox |
| we_i | input | 1 | Register write enable |
| addr_i | input | 1 | Register select: 0 is status, 1 is enable mask |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the selected register |
| flags_o | output | 4 | Flags as {rx warn, tx warn, remote, data} |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every input is synchronous to the clock and holds steady from one edge to the next. They also assume that the counters, bus-off and the mailbox vectors can change in any cycle and by any amount. The bench drives all inputs just after the falling edge. It holds the counters near the threshold of 96, so that rising and falling edges of each warning condition happen often, and it sometimes drives bus-off high. It also issues write-1 clears in the same cycles as set edges, which exercises the priority between them.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned BIT_RXW   = 4;
  localparam int unsigned BIT_TXW   = 3;
  localparam int unsigned BIT_RMT   = 2;
  localparam int unsigned BIT_DAT   = 1;
  localparam int unsigned WARN_LVL  = 96;

  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_IEN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/can_irq_warn_flag.sv
module can_irq_warn_flag #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned THRESH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             block_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] LVL = CNT_W'(THRESH);

  logic cond, cond_q, flag_q, set_edge;

  assign cond     = (cnt_i >= LVL) && !block_i;
  assign set_edge = cond && !cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cond_q <= cond;
      // set edge has priority over write-1 clear
      if (set_edge)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/can_irq_summary.sv
module can_irq_summary #(
  parameter int unsigned N_MBX = 32
) (
  input  logic [N_MBX-1:0] pend_i,
  input  logic [N_MBX-1:0] mask_i,
  output logic             any_o
);
  assign any_o = |(pend_i & ~mask_i);
endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
  import can_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic                 clr_rx_o,
  output logic                 clr_tx_o,
  output logic [NUM_FLAGS-1:0] ien_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int unsigned LO = BIT_DAT;
  localparam int unsigned HI = BIT_RXW;

  logic [NUM_FLAGS-1:0] ien_q;
  logic wr_stat, wr_ien;
  logic unused_wdata;

  assign wr_stat = we_i && (reg_sel_e'(addr_i) == SEL_STAT);
  assign wr_ien  = we_i && (reg_sel_e'(addr_i) == SEL_IEN);

  assign clr_rx_o = wr_stat && wdata_i[BIT_RXW];
  assign clr_tx_o = wr_stat && wdata_i[BIT_TXW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '1;
    else if (wr_ien) ien_q <= wdata_i[HI:LO];
  end

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(addr_i) == SEL_STAT) rdata_o[HI:LO] = flags_i;
    else                                rdata_o[HI:LO] = ien_q;
  end

  assign ien_o        = ien_q;
  assign unused_wdata = ^{wdata_i[DATA_W-1:HI+1], wdata_i[LO-1:0]};
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int unsigned N_MBX  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     rx_err_cnt_i,
  input  logic [CNT_W-1:0]     tx_err_cnt_i,
  input  logic                 bus_off_i,
  input  logic [N_MBX-1:0]     rmt_pend_i,
  input  logic [N_MBX-1:0]     dat_pend_i,
  input  logic [N_MBX-1:0]     mbx_mask_i,
  input  logic                 we_i,
  input  logic                 addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  logic rx_warn, tx_warn, rmt_any, dat_any;
  logic clr_rx, clr_tx;
  logic [NUM_FLAGS-1:0] ien;

  can_irq_warn_flag #(.CNT_W(CNT_W), .THRESH(WARN_LVL)) u_rx_warn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (rx_err_cnt_i),
    .block_i(bus_off_i),
    .clr_i  (clr_rx),
    .flag_o (rx_warn)
  );

  can_irq_warn_flag #(.CNT_W(CNT_W), .THRESH(WARN_LVL)) u_tx_warn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (tx_err_cnt_i),
    .block_i(1'b0),
    .clr_i  (clr_tx),
    .flag_o (tx_warn)
  );

  can_irq_summary #(.N_MBX(N_MBX)) u_rmt_sum (
    .pend_i(rmt_pend_i),
    .mask_i(mbx_mask_i),
    .any_o (rmt_any)
  );

  can_irq_summary #(.N_MBX(N_MBX)) u_dat_sum (
    .pend_i(dat_pend_i),
    .mask_i(mbx_mask_i),
    .any_o (dat_any)
  );

  assign flags_o = {rx_warn, tx_warn, rmt_any, dat_any};

  can_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flags_i (flags_o),
    .clr_rx_o(clr_rx),
    .clr_tx_o(clr_tx),
    .ien_o   (ien),
    .rdata_o (rdata_o)
  );

  assign irq_o = |(flags_o & ~ien);
endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk #(
  parameter int unsigned N_MBX  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  rx_err_cnt_i,
  input logic [CNT_W-1:0]  tx_err_cnt_i,
  input logic              bus_off_i,
  input logic [N_MBX-1:0]  rmt_pend_i,
  input logic [N_MBX-1:0]  dat_pend_i,
  input logic [N_MBX-1:0]  mbx_mask_i,
  input logic              we_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [3:0]        flags_o,
  input logic [3:0]        ien,
  input logic              irq_o
);
  logic rx_hit, tx_hit, rx_hit_h, tx_hit_h;
  assign rx_hit = (int'(rx_err_cnt_i) >= 96) && !bus_off_i;
  assign tx_hit = int'(tx_err_cnt_i) >= 96;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_hit_h <= 1'b0;
      tx_hit_h <= 1'b0;
    end else begin
      rx_hit_h <= rx_hit;
      tx_hit_h <= tx_hit;
    end
  end

  a_r1_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_hit && !rx_hit_h) |=> flags_o[3]);

  a_r2_busoff_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_i && !flags_o[3]) |=> !flags_o[3]);

  a_r3_tx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_hit && !tx_hit_h) |=> flags_o[2]);

  a_r4_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i && wdata_i[4] && !(rx_hit && !rx_hit_h)) |=> !flags_o[3]);

  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[2] && !(we_i && !addr_i && wdata_i[3])) |=> flags_o[2]);

  a_r6_remote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] == |(rmt_pend_i & ~mbx_mask_i));

  a_r7_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[0] == |(dat_pend_i & ~mbx_mask_i));

  a_r9_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(flags_o & ~ien));
endmodule

bind can_irq_flags can_irq_flags_chk #(.N_MBX(N_MBX), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_err_cnt_i(rx_err_cnt_i),
  .tx_err_cnt_i(tx_err_cnt_i),
  .bus_off_i   (bus_off_i),
  .rmt_pend_i  (rmt_pend_i),
  .dat_pend_i  (dat_pend_i),
  .mbx_mask_i  (mbx_mask_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .flags_o     (flags_o),
  .ien         (ien),
  .irq_o       (irq_o)
);

// File: tb/can_irq_flags_tb.sv
module can_irq_flags_tb;
  localparam int N = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx = '0, tx = '0;
  logic boff = 1'b0;
  logic [N-1:0] rmt = '0, dat = '0, msk = '0;
  logic we = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [3:0] flags;
  logic irq;

  int errs = 0, checks = 0;
  bit done = 0;
  bit run = 0;

  always #5 clk = ~clk;

  can_irq_flags #(.N_MBX(N), .DATA_W(DW), .CNT_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_err_cnt_i(rx), .tx_err_cnt_i(tx),
    .bus_off_i(boff), .rmt_pend_i(rmt), .dat_pend_i(dat), .mbx_mask_i(msk),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .flags_o(flags), .irq_o(irq)
  );

  // behavioural reference
  bit m_rx, m_tx, m_rxc, m_txc;
  bit [3:0] m_ien;
  always @(posedge clk or negedge rst_n) begin
    bit rc, tc;
    if (!rst_n) begin
      m_rx <= 0; m_tx <= 0; m_rxc <= 0; m_txc <= 0; m_ien <= 4'hF;
    end else begin
      rc = (int'(rx) >= 96) && !boff;
      tc = int'(tx) >= 96;
      if (rc && !m_rxc) m_rx <= 1;
      else if (we && addr == 0 && wdata[4]) m_rx <= 0;
      if (tc && !m_txc) m_tx <= 1;
      else if (we && addr == 0 && wdata[3]) m_tx <= 0;
      m_rxc <= rc;
      m_txc <= tc;
      if (we && addr == 1) m_ien <= wdata[4:1];
    end
  end

  function automatic bit any_open(logic [N-1:0] p, logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (p[i] && !m[i]) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run && rst_n) begin
      bit [3:0] ef;
      bit [DW-1:0] er;
      ef = {m_rx, m_tx, any_open(rmt, msk), any_open(dat, msk)};
      er = '0;
      er[4:1] = addr ? m_ien : ef;
      chk("R1 rx warn", DW'(flags[3]), DW'(ef[3]));
      chk("R3 tx warn", DW'(flags[2]), DW'(ef[2]));
      chk("R6 remote", DW'(flags[1]), DW'(ef[1]));
      chk("R7 data", DW'(flags[0]), DW'(ef[0]));
      chk("R9 irq", DW'(irq), DW'(|(ef & ~m_ien)));
      chk("R8 rdata", rdata, er);
    end
  end

  task automatic nx(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(bit a, logic [DW-1:0] d);
    we = 1; addr = a; wdata = d;
    nx();
    we = 0; wdata = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    nx(3);
    addr = 1;
    #1;
    chk("R10 ien reset", rdata, 32'h1E);
    chk("R10 flags reset", DW'(flags), 0);
    rst_n = 1;
    run = 1;
    nx();
    addr = 0;
    // R1
    rx = 100;
    nx();
    chk("R1 set", DW'(flags[3]), 1);
    // R4 clear holds while counter high
    wr(0, 32'h10);
    chk("R4 clear", DW'(flags[3]), 0);
    nx(3);
    chk("R4 stays clear", DW'(flags[3]), 0);
    // R3 and R4 write 0 no effect
    tx = 120;
    nx();
    chk("R3 set", DW'(flags[2]), 1);
    wr(0, 32'hFFFF_FFE7);
    chk("R4 write0", DW'(flags[3:2]), 2'b01);
    wr(0, 32'h08);
    chk("R4 tx clear", DW'(flags[2]), 0);
    // R2
    rx = 0; tx = 0;
    nx();
    boff = 1; rx = 150; tx = 97;
    nx(2);
    chk("R2 busoff rx", DW'(flags[3]), 0);
    chk("R2 tx ignores busoff", DW'(flags[2]), 1);
    boff = 0; rx = 0;
    nx();
    // R5
    rx = 96;
    wr(0, 32'h10);
    chk("R5 set wins", DW'(flags[3]), 1);
    wr(0, 32'h18);
    // R6
    rmt[5] = 1;
    nx();
    chk("R6 remote on", DW'(flags[1]), 1);
    msk[5] = 1;
    nx();
    chk("R6 all masked", DW'(flags[1]), 0);
    rmt = '0; msk = '0;
    // R7
    dat[31] = 1; dat[0] = 1; msk[0] = 1;
    nx();
    chk("R7 data on", DW'(flags[0]), 1);
    msk[31] = 1;
    nx();
    chk("R7 all masked", DW'(flags[0]), 0);
    // R8
    wr(0, 32'h6);
    chk("R8 ro write", DW'(flags[1:0]), 0);
    dat = '1; msk = '0;
    #1;
    chk("R8 unused bits", rdata & 32'hFFFF_FFE1, 0);
    // R9
    chk("R9 masked irq", DW'(irq), 0);
    wr(1, 32'h1C);
    addr = 1;
    #1;
    chk("R9 ien read", rdata, 32'h1C);
    chk("R9 irq on", DW'(irq), 1);
    addr = 0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      nx();
      rx = 8'($urandom_range(90, 101));
      tx = 8'($urandom_range(90, 101));
      boff = ($urandom_range(0, 7) == 0);
      rmt = N'($urandom) & N'($urandom) & N'($urandom);
      dat = N'($urandom) & N'($urandom);
      msk = N'($urandom) | N'($urandom);
      we = ($urandom_range(0, 3) == 0);
      addr = 1'($urandom);
      wdata = $urandom;
    end
    nx();
    we = 0;
    nx(2);
    run = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule